// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the register-transfer datapath of a processor that completes each instruction over several clock cycles. It holds one ALU and one memory port, and both are shared across the cycles of an instruction. The block contains the program counter, the instruction register, a memory data register, two operand latches, an ALU result register, a 32-entry register file and the steering multiplexers around them. It makes no decisions of its own. Every select line and write enable is an input, driven each cycle by an external control sequencer.

The sequencer reads the opcode and function fields and the zero flag back from the block. Memory sits outside the block. The block presents an address and store data, and it takes read data back. It handles the datapath needs of add, subtract, and, or, set-on-less-than, word load, word store and branch-on-equal.

Top module: `mc_datapath`

## Requirements
- R1: While rst_n is low, the PC and the instruction register clear to zero. After reset, opcode and funct read 0, and mem_addr reads 0 when addr_sel=0.
- R2: The instruction register loads mem_rdata at a clock edge only when ir_wr=1 and holds its value otherwise. opcode shows instruction bits [31:26] and funct shows bits [5:0].
- R3: The operand latches A and B, the ALU result register and the memory data register load at every clock edge with no enable. A takes the register named by instruction bits [25:21]. B takes the register named by bits [20:16]. mem_wdata always shows B.
- R4: srca_sel=0 feeds the PC to the ALU's first input and srca_sel=1 feeds A. srcb_sel picks the second input: 0 is B, 1 is the constant 4, 2 is the sign-extended bits [15:0], and 3 is that value shifted left by two.
- R5: alu_op encodes the ALU operation as follows: 3'b010 add, 3'b110 subtract, 3'b000 AND, 3'b001 OR, 3'b111 signed set-on-less-than (result 1 or 0). Any other code gives 0.
- R6: zero is high in the same cycle that the live ALU result is zero.
- R7: addr_sel=0 puts the PC on mem_addr and addr_sel=1 puts the ALU result register on mem_addr.
- R8: The PC loads only at an edge where pc_wr=1. It takes the live ALU result when pc_src=0 and the ALU result register when pc_src=1.
- R9: When reg_wr=1, a register is written at the clock edge. dst_sel=1 picks instruction bits [15:11] as the target and dst_sel=0 picks bits [20:16]. wb_sel=0 writes the ALU result register and wb_sel=1 writes the memory data register.
- R10: Register 0 always reads as zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_wr | input | 1 | PC load enable |
| pc_src | input | 1 | Next PC: 0 live ALU result, 1 ALU result register |
| ir_wr | input | 1 | Instruction register load enable |
| addr_sel | input | 1 | Memory address: 0 PC, 1 ALU result register |
| reg_wr | input | 1 | Register file write enable |
| dst_sel | input | 1 | Write target: 1 bits [15:11], 0 bits [20:16] |
| wb_sel | input | 1 | Write data: 0 ALU result register, 1 memory data register |
| srca_sel | input | 1 | ALU input A: 0 PC, 1 latch A |
| srcb_sel | input | 2 | ALU input B select |
| alu_op | input | 3 | ALU operation code |
| mem_rdata | input | 32 | Data read from memory |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Store data (latch B) |
| opcode | output | 6 | Instruction bits [31:26] |
| funct | output | 6 | Instruction bits [5:0] |
| zero | output | 1 | Live ALU result equals zero |

## Verification
The assertions check on every cycle the rules that span one clock edge:
- the instruction register and PC hold when their enables are low;
- the instruction register and memory data register capture mem_rdata;
- the PC takes the ALU result register when pc_src=1;
- an operand latch reads zero after its source field names register 0.

The bench's scenarios are needed for the rest, because those checks depend on a modelled register file and on the operand encodings:
- ALU results for each operation code;
- zero flag timing;
- sign extension of negative immediates;
- branch targets;
- write-back through both target fields and both data sources.

// File: rtl/mc_datapath.sv
module mc_datapath #(
  parameter int DW  = 32,
  parameter int RAW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pc_wr,
  input  logic          pc_src,
  input  logic          ir_wr,
  input  logic          addr_sel,
  input  logic          reg_wr,
  input  logic          dst_sel,
  input  logic          wb_sel,
  input  logic          srca_sel,
  input  logic [1:0]    srcb_sel,
  input  logic [2:0]    alu_op,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [5:0]    opcode,
  output logic [5:0]    funct,
  output logic          zero
);
  localparam int NREG = 1 << RAW;
  localparam int IMMW = 16;

  logic [DW-1:0] pc, ir, mdr, a_q, b_q, res_q;
  logic [DW-1:0] rf [NREG];
  logic [DW-1:0] opa, opb, res, imm_x, wd;
  logic [RAW-1:0] rs, rt, rd, wa;

  assign rs     = ir[25:21];
  assign rt     = ir[20:16];
  assign rd     = ir[15:11];
  assign opcode = ir[31:26];
  assign funct  = ir[5:0];
  assign imm_x  = {{(DW-IMMW){ir[IMMW-1]}}, ir[IMMW-1:0]};

  assign wa = dst_sel ? rd : rt;
  assign wd = wb_sel ? mdr : res_q;

  assign opa = srca_sel ? a_q : pc;
  always_comb begin
    case (srcb_sel)
      2'd0:    opb = b_q;
      2'd1:    opb = DW'(4);
      2'd2:    opb = imm_x;
      default: opb = imm_x << 2;
    endcase
  end

  always_comb begin
    case (alu_op)
      3'b010:  res = opa + opb;
      3'b110:  res = opa - opb;
      3'b000:  res = opa & opb;
      3'b001:  res = opa | opb;
      3'b111:  res = {{(DW-1){1'b0}}, $signed(opa) < $signed(opb)};
      default: res = '0;
    endcase
  end

  assign zero      = (res == '0);
  assign mem_addr  = addr_sel ? res_q : pc;
  assign mem_wdata = b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc    <= '0;
      ir    <= '0;
      mdr   <= '0;
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
    end else begin
      if (pc_wr) pc <= pc_src ? res_q : res;
      if (ir_wr) ir <= mem_rdata;
      mdr   <= mem_rdata;
      a_q   <= (rs == '0) ? '0 : rf[rs];
      b_q   <= (rt == '0) ? '0 : rf[rt];
      res_q <= res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (reg_wr && wa != '0) begin
      rf[wa] <= wd;
    end
  end

  // R2
  ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_wr |=> $stable(ir));
  // R2
  ir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ir_wr |=> ir == $past(mem_rdata));
  // R3
  mdr_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> mdr == $past(mem_rdata));
  // R8
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_wr |=> $stable(pc));
  // R8
  pc_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && pc_src) |=> pc == $past(res_q));
  // R10
  r0_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs == '0) |=> a_q == '0);
endmodule

// File: tb/mc_datapath_tb.sv
module mc_datapath_tb;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic pc_wr, pc_src, ir_wr, addr_sel, reg_wr, dst_sel, wb_sel, srca_sel;
  logic [1:0] srcb_sel;
  logic [2:0] alu_op;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic [5:0] opcode, funct;
  logic zero;

  int total = 0, bad = 0;
  logic [31:0] model [32];
  logic [31:0] pc_m;

  always #(PERIOD/2) clk = ~clk;

  mc_datapath u_dut (
    .clk(clk), .rst_n(rst_n), .pc_wr(pc_wr), .pc_src(pc_src), .ir_wr(ir_wr),
    .addr_sel(addr_sel), .reg_wr(reg_wr), .dst_sel(dst_sel), .wb_sel(wb_sel),
    .srca_sel(srca_sel), .srcb_sel(srcb_sel), .alu_op(alu_op),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .opcode(opcode), .funct(funct), .zero(zero));

  function automatic logic [31:0] alu_f(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    case (op)
      3'b010: return a + b;
      3'b110: return a - b;
      3'b000: return a & b;
      3'b001: return a | b;
      3'b111: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] sx(logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    pc_wr = 0; pc_src = 0; ir_wr = 0; addr_sel = 0; reg_wr = 0; dst_sel = 0;
    wb_sel = 0; srca_sel = 0; srcb_sel = 0; alu_op = 3'b010;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic load_ir(logic [31:0] instr);
    idle(); ir_wr = 1; mem_rdata = instr; tick(); ir_wr = 0;
  endtask

  task automatic write_reg(logic [4:0] r, logic [31:0] v);
    load_ir({6'd35, 5'd0, r, 16'd0});
    mem_rdata = v; tick();
    reg_wr = 1; wb_sel = 1; dst_sel = 0; tick();
    idle();
    if (r != 0) model[r] = v;
  endtask

  task automatic read_b(logic [4:0] r, string req);
    load_ir({6'd43, 5'd0, r, 16'd0});
    tick();
    chk(mem_wdata == model[r], req, mem_wdata, model[r]);
  endtask

  task automatic alu_run(logic [2:0] op, logic [4:0] ra, logic [4:0] rb, logic [4:0] rd);
    logic [31:0] exp;
    exp = alu_f(op, model[ra], model[rb]);
    load_ir({6'd0, ra, rb, rd, 5'd0, 6'h20});
    tick();
    srca_sel = 1; srcb_sel = 0; alu_op = op; #1;
    chk(zero == (exp == 0), "R6 zero flag", {31'd0, zero}, {31'd0, exp == 0});
    tick();
    addr_sel = 1; #1;
    chk(mem_addr == exp, "R5 alu result", mem_addr, exp);
    reg_wr = 1; dst_sel = 1; wb_sel = 0; tick();
    idle();
    if (rd != 0) model[rd] = exp;
    read_b(rd, "R9 rd writeback");
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [2:0] ops [5];
    void'($urandom(32'h5eed));
    ops[0] = 3'b010; ops[1] = 3'b110; ops[2] = 3'b000; ops[3] = 3'b001; ops[4] = 3'b111;
    for (int i = 0; i < 32; i++) model[i] = 0;
    idle(); mem_rdata = 32'hdead_beef;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(mem_addr == 0, "R1 pc reset", mem_addr, 0);
    chk(opcode == 0 && funct == 0, "R1 ir reset", {20'd0, opcode, funct}, 0);
    rst_n = 1; tick();
    pc_m = 0;

    // R2 load and hold
    load_ir(32'h8C41_002A);
    chk(opcode == 6'h23 && funct == 6'h2A, "R2 ir fields", {20'd0, opcode, funct}, {20'd0, 6'h23, 6'h2A});
    mem_rdata = 32'h0000_0000; tick();
    chk(opcode == 6'h23 && funct == 6'h2A, "R2 ir hold", {20'd0, opcode, funct}, {20'd0, 6'h23, 6'h2A});

    // R3/R9 writes through memory data register and B readback
    write_reg(5'd3, 32'h1234_5678);
    write_reg(5'd4, 32'hFFFF_FFF0);
    read_b(5'd3, "R3 operand latch B");
    read_b(5'd4, "R9 rt writeback");

    // R10 register zero
    write_reg(5'd0, 32'hCAFE_F00D);
    read_b(5'd0, "R10 reg0 reads zero");

    // R5 each op, directed
    alu_run(3'b110, 5'd3, 5'd3, 5'd5);
    alu_run(3'b111, 5'd4, 5'd3, 5'd6);
    alu_run(3'b111, 5'd3, 5'd4, 5'd7);
    alu_run(3'b011, 5'd3, 5'd4, 5'd8);
    alu_run(3'b010, 5'd3, 5'd4, 5'd0);

    // R4/R7 A plus sign-extended immediate
    load_ir({6'd35, 5'd4, 5'd0, 16'hFFF8});
    tick();
    srca_sel = 1; srcb_sel = 2; alu_op = 3'b010; tick();
    addr_sel = 1; #1;
    chk(mem_addr == model[4] + sx(16'hFFF8), "R4 imm operand", mem_addr, model[4] + sx(16'hFFF8));

    // R8 fetch increment
    idle(); #1;
    chk(mem_addr == pc_m, "R7 pc address", mem_addr, pc_m);
    pc_wr = 1; pc_src = 0; srca_sel = 0; srcb_sel = 1; alu_op = 3'b010; tick();
    pc_m = pc_m + 4; idle(); #1;
    chk(mem_addr == pc_m, "R8 pc plus 4", mem_addr, pc_m);
    pc_wr = 1; pc_src = 0; srca_sel = 0; srcb_sel = 1; alu_op = 3'b010; tick();
    pc_m = pc_m + 4; idle();

    // R8 branch target through result register
    load_ir({6'd4, 5'd3, 5'd3, 16'hFFFF});
    srca_sel = 0; srcb_sel = 3; alu_op = 3'b010; tick();
    pc_wr = 1; pc_src = 1; srca_sel = 1; srcb_sel = 0; alu_op = 3'b110; #1;
    chk(zero == 1'b1, "R6 equal compare", {31'd0, zero}, 1);
    tick();
    pc_m = pc_m + (sx(16'hFFFF) << 2);
    idle(); #1;
    chk(mem_addr == pc_m, "R8 branch target", mem_addr, pc_m);
    mem_rdata = 32'h0; tick();
    chk(mem_addr == pc_m, "R8 pc hold", mem_addr, pc_m);

    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [4:0] ra, rb, rd;
      ra = 5'($urandom_range(1, 31));
      rb = 5'($urandom_range(1, 31));
      rd = 5'($urandom_range(0, 31));
      write_reg(ra, (i % 4 == 0) ? 32'd0 : $urandom);
      write_reg(rb, (i % 5 == 0) ? model[ra] : $urandom);
      alu_run(ops[$urandom_range(0, 4)], ra, rb, rd);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule